// File: doc/BRIEF.md
# Load/Store Buffer with Two-Phase Memory Access

This block holds the pending memory operations of an out-of-order core that renames registers through tags. Issue logic drops a load or a store into a free slot together with the tag or value of its base operand, the tag or value of its store data, an immediate offset and, for loads only, the tag the result will carry. Slots whose operands are still being produced watch the result bus and take each value as soon as its tag appears there.

One sequencer owns a single synchronous memory port. It serves slots strictly in the order they were allocated. When the oldest slot has every operand it needs, the sequencer spends one cycle forming the effective address (base plus offset, written back over the offset field). It spends the next cycle on the memory access. A store then leaves the buffer. A load waits one cycle for the read data, then raises a request on the result bus with its tag and value, and holds that request until the bus grants it. When every slot is occupied, the block tells issue to stall.

Top module: `ldst_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, the buffer is empty: `alloc_stall`, `mem_en` and `res_req` are all low.
- R2: At allocation a slot records the operation kind (`alloc_store` = 1 for a store), the operands and the offset. A load keeps `alloc_dest_tag` and later presents it on `res_tag`. A store keeps no tag and never raises `res_req`.
- R3: `alloc_stall` is high exactly when all DEPTH slots are occupied. An allocation offered while `alloc_stall` is high is dropped and never reaches memory.
- R4: Tag value 0 means the operand is present. A slot waiting on a non-zero tag takes `snoop_data` when `snoop_valid` is high and `snoop_tag` equals that tag, even in the same cycle the slot is allocated. A base operand keeps the low ADDR_W bits of the data.
- R5: An operation starts only when its base tag is 0. A store also needs its data tag to be 0, even when its base is already present.
- R6: The address cycle computes (base + offset) modulo 2^ADDR_W. In the next cycle `mem_en` is high for exactly one cycle with that address on `mem_addr`.
- R7: In its access cycle a store drives `mem_we` high and its data on `mem_wdata`. It frees its slot at the end of that cycle without using the result bus.
- R8: A load drives `mem_we` low in its access cycle. Two cycles later it raises `res_req`, with the word read on `res_data`. It holds `res_req`, `res_tag` and `res_data` unchanged until a cycle in which `res_grant` is high, and frees its slot at that point.
- R9: Operations are served strictly in allocation order, one at a time. `mem_en` is never high in two consecutive cycles, and it is never high while `res_req` is high.
- R10: Freeing a slot in a full buffer lowers `alloc_stall` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue offers an operation |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_base_tag | input | TAG_W | Producer tag of the base operand, 0 if present |
| alloc_base_val | input | ADDR_W | Base operand value when present |
| alloc_data_tag | input | TAG_W | Producer tag of the store data, 0 if present |
| alloc_data_val | input | DATA_W | Store data when present |
| alloc_imm | input | ADDR_W | Immediate offset |
| alloc_dest_tag | input | TAG_W | Result tag of a load |
| alloc_stall | output | 1 | All slots occupied |
| snoop_valid | input | 1 | Result bus carries a value |
| snoop_tag | input | TAG_W | Tag on the result bus |
| snoop_data | input | DATA_W | Value on the result bus |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| res_req | output | 1 | Load result requests the result bus |
| res_tag | output | TAG_W | Tag of the load result |
| res_data | output | DATA_W | Loaded value |
| res_grant | input | 1 | Result bus accepts the request |

## Verification
Two events can land in the same cycle. One is an allocation while the result bus broadcasts the very tag the new slot names. The bench provokes it by raising `alloc_valid` and `snoop_valid` together, then judges it by the address and data the slot later drives. The other is a slot being freed while the buffer is full and issue offers another operation. The bench fills all slots behind a blocked head, offers an extra store during the stall, and confirms from the memory traffic that the dropped store never appears and that the stall lifts one cycle after the first free. A behavioural queue model compares the stall, the memory port and the result-bus outputs on every clock.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  // Sequencer phases of the single memory port
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // address cycle happens here when head is ready
    PH_ACC  = 2'd1,  // memory access cycle
    PH_CAP  = 2'd2,  // load read data returning
    PH_BUS  = 2'd3   // load result waiting for bus grant
  } lsb_phase_e;

endpackage

// File: rtl/lsb_entry.sv
module lsb_entry #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_st,
  input  logic [TAG_W-1:0]  wr_qb,
  input  logic [ADDR_W-1:0] wr_vb,
  input  logic [TAG_W-1:0]  wr_qd,
  input  logic [DATA_W-1:0] wr_vd,
  input  logic [ADDR_W-1:0] wr_imm,
  input  logic [TAG_W-1:0]  wr_dst,
  input  logic              snp_vld,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [DATA_W-1:0] snp_dat,
  input  logic              agen_en,
  input  logic              clr_en,
  output logic              busy,
  output logic              is_st,
  output logic [TAG_W-1:0]  qb,
  output logic [TAG_W-1:0]  qd,
  output logic [DATA_W-1:0] vd,
  output logic [ADDR_W-1:0] ea,
  output logic [TAG_W-1:0]  dst
);

  logic [ADDR_W-1:0] vb;
  logic [ADDR_W-1:0] a_q;

  // a broadcast is usable only with a non-zero tag
  logic snp_live;
  assign snp_live = snp_vld && (snp_tag != '0);

  // allocation-time bypass from the result bus
  logic new_b_hit, new_d_hit, b_hit, d_hit;
  assign new_b_hit = snp_live && (wr_qb == snp_tag);
  assign new_d_hit = snp_live && (wr_qd == snp_tag);
  assign b_hit     = busy && snp_live && (qb == snp_tag);
  assign d_hit     = busy && snp_live && (qd == snp_tag);

  assign ea = vb + a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      is_st <= 1'b0;
      qb    <= '0;
      qd    <= '0;
      vb    <= '0;
      vd    <= '0;
      a_q   <= '0;
      dst   <= '0;
    end else if (wr_en) begin
      busy  <= 1'b1;
      is_st <= wr_st;
      qb    <= new_b_hit ? '0 : wr_qb;
      vb    <= new_b_hit ? snp_dat[ADDR_W-1:0] : wr_vb;
      qd    <= new_d_hit ? '0 : wr_qd;
      vd    <= new_d_hit ? snp_dat : wr_vd;
      a_q   <= wr_imm;
      dst   <= wr_st ? '0 : wr_dst;
    end else begin
      if (clr_en) busy <= 1'b0;
      if (b_hit) begin
        qb <= '0;
        vb <= snp_dat[ADDR_W-1:0];
      end
      if (d_hit) begin
        qd <= '0;
        vd <= snp_dat;
      end
      if (agen_en) a_q <= ea;
    end
  end

endmodule

// File: rtl/lsb_seq.sv
module lsb_seq
  import lsb_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_busy,
  input  logic              head_st,
  input  logic [TAG_W-1:0]  head_qb,
  input  logic [TAG_W-1:0]  head_qd,
  input  logic [ADDR_W-1:0] head_ea,
  input  logic [DATA_W-1:0] head_vd,
  input  logic [TAG_W-1:0]  head_dst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              res_grant,
  output logic              agen_en,
  output logic              pop,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              res_req,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);

  lsb_phase_e ph;
  logic       ready;

  always_comb begin
    ready   = head_busy && (head_qb == '0) && (!head_st || (head_qd == '0));
    agen_en = (ph == PH_IDLE) && ready;
    pop     = ((ph == PH_ACC) && mem_we) || ((ph == PH_BUS) && res_grant);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      res_req   <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (ready) begin
          mem_en    <= 1'b1;
          mem_we    <= head_st;
          mem_addr  <= head_ea;
          mem_wdata <= head_st ? head_vd : '0;
          ph        <= PH_ACC;
        end
        PH_ACC: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          ph     <= mem_we ? PH_IDLE : PH_CAP;
        end
        PH_CAP: begin
          res_req  <= 1'b1;
          res_tag  <= head_dst;
          res_data <= mem_rdata;
          ph       <= PH_BUS;
        end
        PH_BUS: if (res_grant) begin
          res_req <= 1'b0;
          ph      <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldst_buffer.sv
module ldst_buffer #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_store,
  input  logic [TAG_W-1:0]  alloc_base_tag,
  input  logic [ADDR_W-1:0] alloc_base_val,
  input  logic [TAG_W-1:0]  alloc_data_tag,
  input  logic [DATA_W-1:0] alloc_data_val,
  input  logic [ADDR_W-1:0] alloc_imm,
  input  logic [TAG_W-1:0]  alloc_dest_tag,
  output logic              alloc_stall,
  input  logic              snoop_valid,
  input  logic [TAG_W-1:0]  snoop_tag,
  input  logic [DATA_W-1:0] snoop_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_req,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  input  logic              res_grant
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] head_ptr, tail_ptr;
  logic [CW-1:0] occ;
  logic          alloc_fire, agen_en, pop;

  logic              e_busy [DEPTH];
  logic              e_st   [DEPTH];
  logic [TAG_W-1:0]  e_qb   [DEPTH];
  logic [TAG_W-1:0]  e_qd   [DEPTH];
  logic [DATA_W-1:0] e_vd   [DEPTH];
  logic [ADDR_W-1:0] e_ea   [DEPTH];
  logic [TAG_W-1:0]  e_dst  [DEPTH];

  assign alloc_stall = (occ == CW'(DEPTH));
  assign alloc_fire  = alloc_valid && !alloc_stall;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    lsb_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (alloc_fire && (tail_ptr == PW'(g))),
      .wr_st   (alloc_store),
      .wr_qb   (alloc_base_tag),
      .wr_vb   (alloc_base_val),
      .wr_qd   (alloc_data_tag),
      .wr_vd   (alloc_data_val),
      .wr_imm  (alloc_imm),
      .wr_dst  (alloc_dest_tag),
      .snp_vld (snoop_valid),
      .snp_tag (snoop_tag),
      .snp_dat (snoop_data),
      .agen_en (agen_en && (head_ptr == PW'(g))),
      .clr_en  (pop && (head_ptr == PW'(g))),
      .busy    (e_busy[g]),
      .is_st   (e_st[g]),
      .qb      (e_qb[g]),
      .qd      (e_qd[g]),
      .vd      (e_vd[g]),
      .ea      (e_ea[g]),
      .dst     (e_dst[g])
    );
  end

  lsb_seq #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .head_busy (e_busy[head_ptr]),
    .head_st   (e_st[head_ptr]),
    .head_qb   (e_qb[head_ptr]),
    .head_qd   (e_qd[head_ptr]),
    .head_ea   (e_ea[head_ptr]),
    .head_vd   (e_vd[head_ptr]),
    .head_dst  (e_dst[head_ptr]),
    .mem_rdata (mem_rdata),
    .res_grant (res_grant),
    .agen_en   (agen_en),
    .pop       (pop),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .res_req   (res_req),
    .res_tag   (res_tag),
    .res_data  (res_data)
  );

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      occ      <= '0;
    end else begin
      if (alloc_fire) tail_ptr <= ptr_inc(tail_ptr);
      if (pop)        head_ptr <= ptr_inc(head_ptr);
      case ({alloc_fire, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/ldst_buffer_chk.sv
module ldst_buffer_chk #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_en,
  input logic              mem_we,
  input logic              res_req,
  input logic              res_grant,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DATA_W-1:0] res_data,
  input logic [CW-1:0]     occ
);

  // R9
  mem_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  // R9
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    res_req |-> !mem_en);

  // R7
  store_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> !res_req);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_req && !res_grant) |=> (res_req && $stable(res_tag) && $stable(res_data)));

  // R8
  load_lat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(res_req) |-> ($past(mem_en, 2) && !$past(mem_we, 2)));

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

endmodule

bind ldst_buffer ldst_buffer_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .res_req   (res_req),
  .res_grant (res_grant),
  .res_tag   (res_tag),
  .res_data  (res_data),
  .occ       (occ)
);

// File: tb/ldst_buffer_bench.sv
`timescale 1ns/1ps
module ldst_buffer_bench;
  localparam int DEPTH = 4, TW = 3, DW = 16, AW = 8;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          alloc_valid = 0, alloc_store = 0;
  logic [TW-1:0] alloc_base_tag = 0, alloc_data_tag = 0, alloc_dest_tag = 0;
  logic [AW-1:0] alloc_base_val = 0, alloc_imm = 0;
  logic [DW-1:0] alloc_data_val = 0;
  logic          alloc_stall;
  logic          snoop_valid = 0;
  logic [TW-1:0] snoop_tag = 0;
  logic [DW-1:0] snoop_data = 0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = 0;
  logic          res_req;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;
  logic          res_grant = 1'b1;

  ldst_buffer #(.DEPTH(DEPTH), .TAG_W(TW), .DATA_W(DW), .ADDR_W(AW)) u_ldst_buffer (
    .clk, .rst, .alloc_valid, .alloc_store, .alloc_base_tag, .alloc_base_val,
    .alloc_data_tag, .alloc_data_val, .alloc_imm, .alloc_dest_tag, .alloc_stall,
    .snoop_valid, .snoop_tag, .snoop_data, .mem_en, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata, .res_req, .res_tag, .res_data, .res_grant);

  // memory attached to the port
  logic [DW-1:0] bmem [MSZ];
  int acc_cnt = 0;
  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { bit st; int qb; int vb; int qd; int vd; int a; int dst; } mref_t;
  mref_t mq[$];
  int ref_mem [MSZ];
  int ph = 0, cap = 0;
  int m_en = 0, m_we = 0, m_addr = 0, m_wd = 0, m_req = 0, m_rt = 0, m_rd = 0, m_stall = 0;

  always @(posedge clk) begin : model
    bit was_full;
    mref_t e;
    if (rst) begin
      mq.delete();
      ph = 0; m_en = 0; m_we = 0; m_req = 0; m_stall = 0;
    end else begin
      was_full = (mq.size() == DEPTH);
      case (ph)
        0: if (mq.size() > 0 && mq[0].qb == 0 && (!mq[0].st || mq[0].qd == 0)) begin
             mq[0].a = (mq[0].vb + mq[0].a) % MSZ;
             m_addr = mq[0].a; m_en = 1; m_we = mq[0].st; m_wd = mq[0].vd; ph = 1;
           end
        1: begin
             if (m_we != 0) begin ref_mem[m_addr] = m_wd; void'(mq.pop_front()); ph = 0; end
             else begin cap = ref_mem[m_addr]; ph = 2; end
             m_en = 0; m_we = 0;
           end
        2: begin m_req = 1; m_rt = mq[0].dst; m_rd = cap; ph = 3; end
        default: if (res_grant) begin m_req = 0; void'(mq.pop_front()); ph = 0; end
      endcase
      if (snoop_valid && snoop_tag != 0) begin
        foreach (mq[i]) begin
          if (mq[i].qb == int'(snoop_tag)) begin mq[i].qb = 0; mq[i].vb = int'(snoop_data) % MSZ; end
          if (mq[i].qd == int'(snoop_tag)) begin mq[i].qd = 0; mq[i].vd = int'(snoop_data); end
        end
      end
      if (alloc_valid && !was_full) begin
        e.st = alloc_store; e.qb = alloc_base_tag; e.vb = alloc_base_val;
        e.qd = alloc_data_tag; e.vd = alloc_data_val; e.a = alloc_imm;
        e.dst = alloc_store ? 0 : int'(alloc_dest_tag);
        if (snoop_valid && snoop_tag != 0 && e.qb == int'(snoop_tag)) begin e.qb = 0; e.vb = int'(snoop_data) % MSZ; end
        if (snoop_valid && snoop_tag != 0 && e.qd == int'(snoop_tag)) begin e.qd = 0; e.vd = int'(snoop_data); end
        mq.push_back(e);
      end
      m_stall = (mq.size() == DEPTH);
    end
  end

  // per-cycle comparison, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      chk(alloc_stall == m_stall, "R3", "alloc_stall", alloc_stall, m_stall);
      chk(mem_en == m_en, "R6", "mem_en", mem_en, m_en);
      if (m_en != 0) begin
        chk(mem_we == m_we, "R7", "mem_we", mem_we, m_we);
        chk(int'(mem_addr) == m_addr, "R6", "mem_addr", mem_addr, m_addr);
        if (m_we != 0) chk(int'(mem_wdata) == m_wd, "R7", "mem_wdata", mem_wdata, m_wd);
      end
      chk(res_req == m_req, "R8", "res_req", res_req, m_req);
      if (m_req != 0) begin
        chk(int'(res_tag) == m_rt, "R2", "res_tag", res_tag, m_rt);
        chk(int'(res_data) == m_rd, "R8", "res_data", res_data, m_rd);
      end
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic set_alloc(bit st, int qb, int vb, int qd, int vd, int imm, int dst);
    alloc_valid = 1; alloc_store = st;
    alloc_base_tag = TW'(qb); alloc_base_val = AW'(vb);
    alloc_data_tag = TW'(qd); alloc_data_val = DW'(vd);
    alloc_imm = AW'(imm); alloc_dest_tag = TW'(dst);
  endtask

  task automatic do_alloc(bit st, int qb, int vb, int qd, int vd, int imm, int dst);
    set_alloc(st, qb, vb, qd, vd, imm, dst);
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic bcast(int tag, int data);
    snoop_valid = 1; snoop_tag = TW'(tag); snoop_data = DW'(data);
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    int a0;
    for (int i = 0; i < MSZ; i++) begin
      bmem[i] = DW'(i * 3 + 1);
      ref_mem[i] = (i * 3 + 1) % (1 << DW);
    end
    repeat (3) @(negedge clk);
    // R1: quiet while in reset
    chk(!alloc_stall && !mem_en && !res_req, "R1", "reset outputs",
        {alloc_stall, mem_en, res_req}, 0);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    chk(!alloc_stall && !mem_en && !res_req, "R1", "after reset",
        {alloc_stall, mem_en, res_req}, 0);

    // R6 R7: ready store, then R8 R2: load of the same word
    do_alloc(1, 0, 8'h10, 0, 16'h1234, 4, 6);
    do_alloc(0, 0, 8'h10, 0, 0, 4, 5);
    repeat (10) @(negedge clk);

    // R5: load waits on base tag; R4: upper bus bits dropped for the base
    do_alloc(0, 3, 0, 0, 0, 1, 2);
    a0 = acc_cnt;
    repeat (5) @(negedge clk);
    chk(acc_cnt == a0, "R5", "access before base ready", acc_cnt, a0);
    bcast(3, 16'hAB20);
    repeat (8) @(negedge clk);

    // R5 R9: store waiting on data blocks a younger ready load to the same word
    do_alloc(1, 0, 8'h40, 4, 0, 0, 0);
    do_alloc(0, 0, 8'h40, 0, 0, 0, 1);
    a0 = acc_cnt;
    repeat (6) @(negedge clk);
    chk(acc_cnt == a0, "R9", "younger load passed pending store", acc_cnt, a0);
    bcast(4, 16'h5A5A);
    repeat (10) @(negedge clk);

    // R4: allocation in the same cycle as the matching broadcast
    set_alloc(1, 5, 0, 6, 0, 2, 0);
    snoop_valid = 1; snoop_tag = 5; snoop_data = 16'h0060;
    @(negedge clk);
    alloc_valid = 0;
    snoop_tag = 6; snoop_data = 16'hC0DE;
    @(negedge clk);
    snoop_valid = 0;
    do_alloc(0, 0, 8'h60, 0, 0, 2, 3);
    repeat (10) @(negedge clk);

    // R3 R10: fill behind a blocked head, extra store during the stall is dropped
    do_alloc(0, 7, 0, 0, 0, 0, 1);
    do_alloc(0, 0, 8'h01, 0, 0, 0, 2);
    do_alloc(0, 0, 8'h02, 0, 0, 0, 3);
    do_alloc(0, 0, 8'h03, 0, 0, 0, 4);
    chk(alloc_stall == 1, "R3", "stall when full", alloc_stall, 1);
    do_alloc(1, 0, 8'h99, 0, 16'hDEAD, 0, 0);
    do_alloc(1, 0, 8'h98, 0, 16'hBEEF, 0, 0);
    bcast(7, 16'h0099);
    repeat (4) @(negedge clk);
    chk(alloc_stall == 0, "R10", "stall released after free", alloc_stall, 0);
    repeat (30) @(negedge clk);

    // R8: result held while grant withheld
    res_grant = 0;
    do_alloc(0, 0, 8'hF0, 0, 0, 8'h25, 2);
    repeat (9) @(negedge clk);
    chk(res_req == 1, "R8", "request held", res_req, 1);
    res_grant = 1;
    repeat (4) @(negedge clk);

    // R6: address wrap, then back-to-back stores and a mixed burst
    do_alloc(1, 0, 8'hF8, 0, 16'h7777, 8'h10, 0);
    do_alloc(1, 0, 8'h08, 0, 16'h8888, 0, 0);
    do_alloc(0, 0, 8'h04, 0, 0, 4, 6);
    do_alloc(0, 0, 8'h00, 0, 0, 8, 7);
    repeat (20) @(negedge clk);
    chk(alloc_stall == 0 && !res_req, "R10", "drained", {alloc_stall, res_req}, 0);

    finish_run();
  end

endmodule